// File: doc/BRIEF.md
# Adaptive-Step ADPCM Nibble Decoder

This block turns a stream of 4-bit adaptive delta codes into 16-bit signed PCM. It holds two pieces of state: a running predictor (the accumulator) and a step size that adapts to the signal. Each code presented with its valid strobe moves the predictor by an odd multiple of the step size and then rescales the step size by a factor chosen from the code's magnitude. Both state registers saturate after every update.

The block also keeps the accumulator value from before the most recent update, so that a downstream interpolator can blend old and new samples. A registered done pulse marks every update. A synchronous restart input, or the block reset, returns the decoder to its start state. Fetching codes, pacing them and any gain or panning stage sit outside this block.

Top module: `adpcm_delta_decoder`

## Requirements
- R1: After reset or a restart pulse, `sample_o` and `sample_prev_o` are 0, `done_o` is 0, and the step size is 127.
- R2: On every accepted code (`code_valid_i` high and `restart_i` low), `sample_prev_o` takes the value `sample_o` had before that update.
- R3: The predictor increment magnitude is ((2·m+1)·step)/8, truncated, where m is code bits [2:0]. A first code of 4'h7 after restart gives 238.
- R4: When code bit 3 is set, the increment is the negated magnitude, so rounding is toward zero. A first code of 4'h8 after restart gives -15.
- R5: After each accepted code the step becomes (step·f)/64, truncated, where f is 57 for m = 0..3 and 77, 102, 128, 153 for m = 4..7. The sign bit does not change f.
- R6: The accumulator saturates to the range -32768..32767.
- R7: The step size never drops below 127. A run of 4'h0 codes from restart adds exactly 15 per code.
- R8: The step size never exceeds 24576. After a long run of 4'h7 codes, a 4'h8 code subtracts exactly 3072.
- R9: `done_o` is high in the cycle after an accepted code and low otherwise.
- R10: With `code_valid_i` low, both sample outputs hold their values.
- R11: `restart_i` takes priority over a simultaneous valid code. That code is discarded and no done pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| restart_i | input | 1 | Synchronous decoder restart pulse |
| code_valid_i | input | 1 | Qualifies `code_i` for one update |
| code_i | input | 4 | ADPCM code: bit 3 sign, bits 2:0 magnitude |
| sample_o | output | SAMPLE_W | Current accumulator (signed) |
| sample_prev_o | output | SAMPLE_W | Accumulator before the last update (signed) |
| done_o | output | 1 | Registered one-cycle update strobe |

## Verification
The bench builds the decoder with its default parameters: 16-bit samples, step limits 127 and 24576, and a 24-bit internal product. With these values both step clamps and both sample rails can be reached within a few dozen codes. Short code runs therefore drive the step to its floor and its ceiling and push the accumulator against each rail. Exact hand-computed values pin down the truncation toward zero for negative increments and the one-cycle timing of the update.

// File: rtl/adpcm_delta_pkg.sv
package adpcm_delta_pkg;
  localparam int CODE_W   = 4;
  localparam int FACTOR_W = 8;

  // step adaptation factor in 1/64 units, indexed by code magnitude
  function automatic logic [FACTOR_W-1:0] step_factor(input logic [2:0] mag);
    logic [FACTOR_W-1:0] f;
    case (mag)
      3'd4:    f = 8'd77;
      3'd5:    f = 8'd102;
      3'd6:    f = 8'd128;
      3'd7:    f = 8'd153;
      default: f = 8'd57;
    endcase
    return f;
  endfunction
endpackage

// File: rtl/adpcm_acc_update.sv
module adpcm_acc_update #(
  parameter int SAMPLE_W = 16,
  parameter int STEP_W   = 16,
  parameter int PROD_W   = 24
) (
  input  logic signed [SAMPLE_W-1:0] acc_i,
  input  logic        [STEP_W-1:0]   step_i,
  input  logic        [3:0]          code_i,
  output logic signed [SAMPLE_W-1:0] acc_o
);
  localparam logic signed [PROD_W-1:0] ACC_MAX = PROD_W'((2 ** (SAMPLE_W - 1)) - 1);
  localparam logic signed [PROD_W-1:0] ACC_MIN = -ACC_MAX - PROD_W'(1);

  logic [3:0]                odd_mult;
  logic [PROD_W-1:0]         prod;
  logic [PROD_W-1:0]         inc_mag;
  logic signed [PROD_W-1:0]  inc;
  logic signed [PROD_W-1:0]  acc_ext;
  logic signed [PROD_W-1:0]  sum;

  always_comb begin
    odd_mult = {code_i[2:0], 1'b1};
    prod     = PROD_W'(odd_mult) * PROD_W'(step_i);
    inc_mag  = prod >> 3;
    inc      = code_i[3] ? -$signed(inc_mag) : $signed(inc_mag);
    acc_ext  = {{(PROD_W - SAMPLE_W){acc_i[SAMPLE_W-1]}}, acc_i};
    sum      = acc_ext + inc;
    if (sum > ACC_MAX)      acc_o = ACC_MAX[SAMPLE_W-1:0];
    else if (sum < ACC_MIN) acc_o = ACC_MIN[SAMPLE_W-1:0];
    else                    acc_o = sum[SAMPLE_W-1:0];
  end
endmodule

// File: rtl/adpcm_step_update.sv
module adpcm_step_update
  import adpcm_delta_pkg::*;
#(
  parameter int STEP_W   = 16,
  parameter int PROD_W   = 24,
  parameter int STEP_MIN = 127,
  parameter int STEP_MAX = 24576
) (
  input  logic [STEP_W-1:0] step_i,
  input  logic [2:0]        mag_i,
  output logic [STEP_W-1:0] step_o
);
  localparam logic [PROD_W-1:0] LO = PROD_W'(STEP_MIN);
  localparam logic [PROD_W-1:0] HI = PROD_W'(STEP_MAX);

  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] scaled;

  always_comb begin
    prod   = PROD_W'(step_i) * PROD_W'(step_factor(mag_i));
    scaled = prod >> 6;
    if (scaled > HI)      step_o = HI[STEP_W-1:0];
    else if (scaled < LO) step_o = LO[STEP_W-1:0];
    else                  step_o = scaled[STEP_W-1:0];
  end
endmodule

// File: rtl/adpcm_delta_decoder.sv
module adpcm_delta_decoder #(
  parameter int SAMPLE_W = 16,
  parameter int STEP_W   = 16,
  parameter int PROD_W   = 24,
  parameter int STEP_MIN = 127,
  parameter int STEP_MAX = 24576,
  parameter int STEP_INIT = 127
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       restart_i,
  input  logic                       code_valid_i,
  input  logic [3:0]                 code_i,
  output logic signed [SAMPLE_W-1:0] sample_o,
  output logic signed [SAMPLE_W-1:0] sample_prev_o,
  output logic                       done_o
);
  localparam logic [STEP_W-1:0] STEP_RST = STEP_W'(STEP_INIT);

  logic signed [SAMPLE_W-1:0] acc_q, prev_q, acc_d;
  logic [STEP_W-1:0]          step_q, step_d;
  logic                       done_q;
  logic                       take;

  assign take = code_valid_i && !restart_i;

  adpcm_acc_update #(
    .SAMPLE_W(SAMPLE_W), .STEP_W(STEP_W), .PROD_W(PROD_W)
  ) u_acc (
    .acc_i(acc_q), .step_i(step_q), .code_i(code_i), .acc_o(acc_d)
  );

  adpcm_step_update #(
    .STEP_W(STEP_W), .PROD_W(PROD_W), .STEP_MIN(STEP_MIN), .STEP_MAX(STEP_MAX)
  ) u_step (
    .step_i(step_q), .mag_i(code_i[2:0]), .step_o(step_d)
  );

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      acc_q  <= '0;
      prev_q <= '0;
      step_q <= STEP_RST;
      done_q <= 1'b0;
    end else begin
      done_q <= take;
      if (take) begin
        prev_q <= acc_q;
        acc_q  <= acc_d;
        step_q <= step_d;
      end
    end
  end

  assign sample_o      = acc_q;
  assign sample_prev_o = prev_q;
  assign done_o        = done_q;
endmodule

// File: rtl/adpcm_delta_decoder_chk.sv
module adpcm_delta_decoder_chk #(
  parameter int SAMPLE_W = 16,
  parameter int STEP_W   = 16,
  parameter int STEP_MIN = 127,
  parameter int STEP_MAX = 24576
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       restart_i,
  input logic                       code_valid_i,
  input logic signed [SAMPLE_W-1:0] sample_o,
  input logic signed [SAMPLE_W-1:0] sample_prev_o,
  input logic                       done_o,
  input logic [STEP_W-1:0]          step
);
  a_r1_restart_clears: assert property (@(posedge clk) disable iff (rst)
    restart_i |=> (sample_o == '0 && sample_prev_o == '0 && !done_o));

  a_r2_prev_copy: assert property (@(posedge clk) disable iff (rst)
    (code_valid_i && !restart_i) |=> (sample_prev_o == $past(sample_o)));

  a_r7_step_floor: assert property (@(posedge clk) disable iff (rst)
    step >= STEP_W'(STEP_MIN));

  a_r8_step_ceiling: assert property (@(posedge clk) disable iff (rst)
    step <= STEP_W'(STEP_MAX));

  a_r9_done_after_code: assert property (@(posedge clk) disable iff (rst)
    (code_valid_i && !restart_i) |=> done_o);

  a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    (!code_valid_i && !restart_i) |=> ($stable(sample_o) && $stable(sample_prev_o) && !done_o));

  a_r11_restart_wins: assert property (@(posedge clk) disable iff (rst)
    (restart_i && code_valid_i) |=> !done_o);
endmodule

bind adpcm_delta_decoder adpcm_delta_decoder_chk #(
  .SAMPLE_W(SAMPLE_W), .STEP_W(STEP_W), .STEP_MIN(STEP_MIN), .STEP_MAX(STEP_MAX)
) u_chk (
  .clk(clk), .rst(rst), .restart_i(restart_i), .code_valid_i(code_valid_i),
  .sample_o(sample_o), .sample_prev_o(sample_prev_o), .done_o(done_o), .step(step_q)
);

// File: tb/adpcm_delta_decoder_tb.sv
module adpcm_delta_decoder_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic restart = 1'b0;
  logic valid = 1'b0;
  logic [3:0] code = 4'h0;
  logic signed [15:0] smp, smp_prev;
  logic done;

  int n_checks = 0;
  int n_fail = 0;
  int m_acc, m_prev, m_step;

  always #5 clk = ~clk;

  adpcm_delta_decoder u_dut (
    .clk(clk), .rst(rst), .restart_i(restart), .code_valid_i(valid), .code_i(code),
    .sample_o(smp), .sample_prev_o(smp_prev), .done_o(done)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int factor_of(input int mag);
    case (mag)
      4: return 77;
      5: return 102;
      6: return 128;
      7: return 153;
      default: return 57;
    endcase
  endfunction

  task automatic model_step(input logic [3:0] c);
    int mag, inc;
    mag = int'(c[2:0]);
    inc = ((2 * mag + 1) * m_step) / 8;
    if (c[3]) inc = -inc;
    m_prev = m_acc;
    m_acc = m_acc + inc;
    if (m_acc > 32767) m_acc = 32767;
    if (m_acc < -32768) m_acc = -32768;
    m_step = (m_step * factor_of(mag)) / 64;
    if (m_step > 24576) m_step = 24576;
    if (m_step < 127) m_step = 127;
  endtask

  task automatic do_restart();
    @(negedge clk);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    m_acc = 0; m_prev = 0; m_step = 127;
  endtask

  task automatic send(input logic [3:0] c, input string tag);
    @(negedge clk);
    code = c; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    model_step(c);
    chk({tag, " sample"}, int'(smp), m_acc);
    chk({tag, " prev (R2)"}, int'(smp_prev), m_prev);
    chk("R9 done after code", int'(done), 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 sample at reset", int'(smp), 0);
    chk("R1 prev at reset", int'(smp_prev), 0);
    chk("R1 done at reset", int'(done), 0);
  endtask

  task automatic t_magnitude();
    do_restart();
    send(4'h7, "R3");
    chk("R3 first 4'h7", int'(smp), 238);
    send(4'h4, "R5");
    chk("R5 step 303 used", int'(smp), 578);
    send(4'h0, "R5");
    chk("R5 step 364 used", int'(smp), 623);
    chk("R2 prev after three", int'(smp_prev), 578);
  endtask

  task automatic t_sign();
    do_restart();
    send(4'h8, "R4");
    chk("R4 truncation toward zero", int'(smp), -15);
    for (int i = 0; i < 16; i++) send(4'(i), "R5 mixed");
  endtask

  task automatic t_floor();
    do_restart();
    for (int i = 0; i < 4; i++) send(4'h0, "R7");
    chk("R7 step floor", int'(smp), 60);
  endtask

  task automatic t_ceiling();
    do_restart();
    for (int i = 0; i < 20; i++) send(4'h7, "R6 pos");
    chk("R6 positive rail", int'(smp), 32767);
    send(4'h8, "R8");
    chk("R8 step ceiling", int'(smp), 29695);
  endtask

  task automatic t_neg_rail();
    do_restart();
    for (int i = 0; i < 20; i++) send(4'hF, "R6 neg");
    chk("R6 negative rail", int'(smp), -32768);
  endtask

  task automatic t_idle();
    int a, p;
    do_restart();
    send(4'h6, "R10 setup");
    a = int'(smp); p = int'(smp_prev);
    code = 4'h7;
    repeat (10) @(negedge clk);
    chk("R10 sample held", int'(smp), a);
    chk("R10 prev held", int'(smp_prev), p);
    chk("R9 no done when idle", int'(done), 0);
  endtask

  task automatic t_restart_prio();
    send(4'h3, "R11 setup");
    @(negedge clk);
    code = 4'h7; valid = 1'b1; restart = 1'b1;
    @(negedge clk);
    valid = 1'b0; restart = 1'b0;
    m_acc = 0; m_prev = 0; m_step = 127;
    chk("R11 sample cleared", int'(smp), 0);
    chk("R11 prev cleared", int'(smp_prev), 0);
    chk("R11 no done", int'(done), 0);
    send(4'h7, "R11 fresh");
    chk("R11 step back to 127", int'(smp), 238);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_acc = 0; m_prev = 0; m_step = 127;
    t_reset();
    t_magnitude();
    t_sign();
    t_floor();
    t_ceiling();
    t_neg_rail();
    t_idle();
    t_restart_prio();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule